// File: doc/BRIEF.md
# Dual-Modulus Divider Controller

This block divides a fast input clock by a programmable integer. It models a prescaler that divides by 10 or by 11, and it steers that prescaler through a modulus-select line. A 7-bit main count M and a 4-bit swallow count A set the ratio. At the start of each output cycle the prescaler is held at divide-by-11 for A of its periods. It then divides by 10 for the remaining periods of the main count, so the overall ratio is 10*(M+1)+A. Each output cycle ends with one pulse on the divided output fp, which goes to a phase detector that acts on its rising edge.

When the prescaler enable is low, the prescaler is bypassed and the main counter counts input clocks directly. The M and A programming inputs are sampled into held copies at the output-cycle boundary, or on every clock while the immediate-load input is high. A power-down input freezes all counting. A shared debug output can show the modulus select, the raw prescaler output or fp.

Top module: `dmd_divider`

## Requirements
- R1: While rst_ni is low, fp_o, msel_o, pre_o and dbg_o are 0. Reset leaves the held M and A at 0, so the first fp_o pulse comes 10 input clocks after reset is released.
- R2: With pre_en_i high and A <= M, rising edges of fp_o are 10*(M+1)+A input clocks apart.
- R3: With pre_en_i high, msel_o is high for the first 11*A input clocks of each output cycle, starting in the cycle where fp_o is high, and low for the rest of the cycle. It never goes high when A = 0.
- R4: With pre_en_i high, pre_o gives a one-clock high pulse at the end of each prescaler period. There are exactly M+1 such pulses per output cycle, and two pulses are never in adjacent clocks.
- R5: With pre_en_i low, fp_o repeats every M+1 input clocks, a_i has no effect, and msel_o and pre_o stay 0.
- R6: fp_o is high for exactly one input clock per output cycle whenever the ratio is 2 or more.
- R7: With load_i low, changes to m_i and a_i do not affect the output cycle in progress. They take effect from the next output cycle.
- R8: While load_i is high, m_i and a_i are taken on every clock and govern the cycle in progress. If the main count already equals or exceeds the new M, it wraps on its next count. Example: in bypass, with the count at 10 and M changed from 20 to 5, fp_o rises 2 clocks later.
- R9: While pd_i is high, the prescaler and both counters hold their values and fp_o is 0. On release the cycle resumes, so that output period grows by the number of clocks spent in power-down.
- R10: dbg_sel_i picks dbg_o: 0 gives constant 0, 1 gives msel_o, 2 gives pre_o, 3 gives fp_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-rate input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pre_en_i | input | 1 | 1: prescaled operation; 0: main counter counts input clocks directly |
| m_i | input | 7 | Main count M |
| a_i | input | 4 | Swallow count A |
| load_i | input | 1 | Immediate load of M and A while high |
| pd_i | input | 1 | Power-down: freeze counting, hold fp_o low |
| dbg_sel_i | input | 2 | Debug output source select |
| fp_o | output | 1 | Divided output pulse |
| msel_o | output | 1 | Modulus select to prescaler, 1 = divide by 11 |
| pre_o | output | 1 | Raw prescaler output pulse |
| dbg_o | output | 1 | Shared debug output |

## Verification
The bench walks a table of M, A and bypass settings that covers A = 0, A = M, the smallest and largest counts, and bypass with a non-zero A. For each setting it measures the fp period, the number of clocks with divide-by-11 selected and the number of prescaler pulses. A swallow counter that released the prescaler one period early or late would miss the period by one clock and the select count by eleven. Further directed tests cover the following cases:
- A change of M in mid-cycle without the load strobe must leave the current period unchanged; a design that applied it at once would shorten that period.
- An immediate load that drops M below the running count must wrap within two clocks rather than count on to the counter's full range.
- A power-down must stretch the period by exactly its length, and fp must stay low throughout it.
- Each debug selection is compared against the signal it names.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  typedef enum logic [1:0] {
    DBG_OFF  = 2'd0,
    DBG_MSEL = 2'd1,
    DBG_PRE  = 2'd2,
    DBG_FP   = 2'd3
  } dbg_sel_e;
endpackage

// File: rtl/dmd_prescaler.sv
module dmd_prescaler #(
  parameter int MOD_LO = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  input  logic msel_i,
  output logic tick_o
);
  localparam int CW = $clog2(MOD_LO + 1);
  localparam logic [CW-1:0] LAST_LO = CW'(MOD_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(MOD_LO);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = msel_i ? LAST_HI : LAST_LO;
  // >= tolerates a modulus drop while sitting on the high terminal count
  assign tick_o = en_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (run_i) begin
      if (!en_i || tick_o) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dmd_counters.sv
module dmd_counters #(
  parameter int M_W = 7,
  parameter int A_W = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           pre_en_i,
  input  logic           tick_i,
  input  logic           load_i,
  input  logic [M_W-1:0] m_i,
  input  logic [A_W-1:0] a_i,
  output logic           msel_o,
  output logic           fp_o,
  output logic [M_W-1:0] main_cnt_o
);
  logic [M_W-1:0] mc_q, m_act_q;
  logic [A_W-1:0] sc_q, a_act_q;
  logic           fp_q;
  logic           count_en, wrap, boundary, take;

  assign count_en = pre_en_i ? tick_i : 1'b1;
  assign wrap     = (mc_q >= m_act_q);
  assign boundary = run_i && count_en && wrap;
  assign take     = boundary || load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mc_q <= '0;
      sc_q <= '0;
    end else if (run_i && count_en) begin
      if (wrap) begin
        mc_q <= '0;
        sc_q <= '0;
      end else begin
        mc_q <= mc_q + 1'b1;
        if (sc_q < a_act_q) sc_q <= sc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act_q <= '0;
      a_act_q <= '0;
    end else if (take) begin
      m_act_q <= m_i;
      a_act_q <= a_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fp_q <= 1'b0;
    else         fp_q <= boundary;
  end

  assign msel_o     = pre_en_i && (sc_q < a_act_q);
  assign fp_o       = fp_q;
  assign main_cnt_o = mc_q;
endmodule

// File: rtl/dmd_dbg_mux.sv
module dmd_dbg_mux
  import dmd_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       msel_i,
  input  logic       pre_i,
  input  logic       fp_i,
  output logic       dbg_o
);
  dbg_sel_e sel;
  assign sel = dbg_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      DBG_MSEL: dbg_o = msel_i;
      DBG_PRE:  dbg_o = pre_i;
      DBG_FP:   dbg_o = fp_i;
      default:  dbg_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dmd_divider.sv
module dmd_divider #(
  parameter int M_W    = 7,
  parameter int A_W    = 4,
  parameter int MOD_LO = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pre_en_i,
  input  logic [M_W-1:0] m_i,
  input  logic [A_W-1:0] a_i,
  input  logic           load_i,
  input  logic           pd_i,
  input  logic [1:0]     dbg_sel_i,
  output logic           fp_o,
  output logic           msel_o,
  output logic           pre_o,
  output logic           dbg_o
);
  logic           run;
  logic           tick;
  logic           msel;
  logic           fp;
  logic [M_W-1:0] main_cnt;

  assign run = !pd_i;

  dmd_prescaler #(.MOD_LO(MOD_LO)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pre_en_i),
    .run_i  (run),
    .msel_i (msel),
    .tick_o (tick)
  );

  dmd_counters #(.M_W(M_W), .A_W(A_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .pre_en_i   (pre_en_i),
    .tick_i     (tick),
    .load_i     (load_i),
    .m_i        (m_i),
    .a_i        (a_i),
    .msel_o     (msel),
    .fp_o       (fp),
    .main_cnt_o (main_cnt)
  );

  dmd_dbg_mux u_dbg (
    .sel_i  (dbg_sel_i),
    .msel_i (msel),
    .pre_i  (tick),
    .fp_i   (fp),
    .dbg_o  (dbg_o)
  );

  assign fp_o   = fp;
  assign msel_o = msel;
  assign pre_o  = tick;
endmodule

// File: rtl/dmd_divider_chk.sv
module dmd_divider_chk #(
  parameter int M_W = 7
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           pre_en_i,
  input logic           load_i,
  input logic           pd_i,
  input logic [1:0]     dbg_sel_i,
  input logic           fp_o,
  input logic           msel_o,
  input logic           pre_o,
  input logic           dbg_o,
  input logic [M_W-1:0] main_cnt_i
);
  AST_MSEL_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(msel_o) && pre_en_i && $past(pre_en_i) && !$past(load_i)) |-> fp_o); // R3

  AST_PRE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_o && !pd_i) |=> !pre_o); // R4

  AST_BYPASS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_en_i |-> (!msel_o && !pre_o)); // R5

  AST_FP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_o && pre_en_i) |=> !fp_o); // R6

  AST_PD_FP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !fp_o); // R9

  AST_PD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (main_cnt_i == $past(main_cnt_i))); // R9

  AST_DBG_MSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_sel_i == 2'd1) |-> (dbg_o == msel_o)); // R10

  AST_DBG_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_sel_i == 2'd0) |-> !dbg_o); // R10
endmodule

bind dmd_divider dmd_divider_chk #(.M_W(M_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pre_en_i   (pre_en_i),
  .load_i     (load_i),
  .pd_i       (pd_i),
  .dbg_sel_i  (dbg_sel_i),
  .fp_o       (fp_o),
  .msel_o     (msel_o),
  .pre_o      (pre_o),
  .dbg_o      (dbg_o),
  .main_cnt_i (main_cnt)
);

// File: tb/dmd_divider_bench.sv
module dmd_divider_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pre_en_i = 1'b1;
  logic [6:0] m_i = '0;
  logic [3:0] a_i = '0;
  logic       load_i = 1'b0;
  logic       pd_i = 1'b0;
  logic [1:0] dbg_sel_i = 2'd1;
  logic       fp_o, msel_o, pre_o, dbg_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk_i = ~clk_i;

  dmd_divider u_dmd_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .pre_en_i(pre_en_i), .m_i(m_i), .a_i(a_i),
    .load_i(load_i), .pd_i(pd_i), .dbg_sel_i(dbg_sel_i),
    .fp_o(fp_o), .msel_o(msel_o), .pre_o(pre_o), .dbg_o(dbg_o)
  );

  // columns: pre_en, M, A, period, clocks with msel high
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{1,   0,  0,   10,   0},
    '{1,   3,  2,   42,  22},
    '{1,   7,  0,   80,   0},
    '{1,   7,  7,   87,  77},
    '{1, 127, 15, 1295, 165},
    '{0,   1,  0,    2,   0},
    '{0,  19,  5,   20,   0},
    '{1,  12,  9,  139,  99}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_fp();
    do @(negedge clk_i); while (!fp_o);
  endtask

  // starts on a sample with fp_o high, ends on the next one
  task automatic measure(output int per, output int ms, output int pr, output int fph);
    per = 0; ms = 0; pr = 0; fph = 0;
    do begin
      per++;
      ms  += int'(msel_o);
      pr  += int'(pre_o);
      fph += int'(fp_o);
      @(negedge clk_i);
    end while (!fp_o);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int per, ms, pr, fph, n, mism;
    m_i = 7'd3; a_i = 4'd2;
    #55;
    check("R1 fp in reset", int'(fp_o), 0);
    check("R1 msel in reset", int'(msel_o), 0);
    check("R1 pre in reset", int'(pre_o), 0);
    check("R1 dbg in reset", int'(dbg_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    n = 0;
    do begin @(negedge clk_i); n++; end while (!fp_o);
    check("R1 first fp after reset", n, 10);

    for (int i = 0; i < NV; i++) begin
      pre_en_i = (VEC[i][0] != 0);
      m_i = 7'(VEC[i][1]);
      a_i = 4'(VEC[i][2]);
      wait_fp();
      measure(per, ms, pr, fph);
      check(pre_en_i ? "R2 period" : "R5 period", per, VEC[i][3]);
      check("R3 msel clocks", ms, VEC[i][4]);
      check("R4 prescaler pulses", pr, pre_en_i ? VEC[i][1] + 1 : 0);
      check("R6 fp width", fph, 1);
    end

    // R7 deferred update
    pre_en_i = 1'b1; m_i = 7'd3; a_i = 4'd0;
    wait_fp();
    measure(per, ms, pr, fph);
    m_i = 7'd5;
    measure(per, ms, pr, fph);
    check("R7 current cycle keeps old M", per, 40);
    measure(per, ms, pr, fph);
    check("R7 next cycle uses new M", per, 60);

    // R8 immediate load
    pre_en_i = 1'b0; m_i = 7'd20; a_i = 4'd0;
    wait_fp();
    measure(per, ms, pr, fph);
    m_i = 7'd5; load_i = 1'b1;
    measure(per, ms, pr, fph);
    check("R8 immediate load period", per, 6);
    m_i = 7'd20;
    repeat (10) @(negedge clk_i);
    m_i = 7'd5;
    n = 0;
    do begin @(negedge clk_i); n++; end while (!fp_o);
    check("R8 wrap when count beyond new M", n, 2);
    load_i = 1'b0;

    // R9 power-down
    pre_en_i = 1'b1; m_i = 7'd3; a_i = 4'd2;
    wait_fp();
    measure(per, ms, pr, fph);
    pd_i = 1'b1;
    n = 0; fph = 0;
    repeat (50) begin
      @(negedge clk_i);
      n++;
      fph += int'(fp_o);
    end
    pd_i = 1'b0;
    check("R9 fp low during power-down", fph, 0);
    do begin @(negedge clk_i); n++; end while (!fp_o);
    check("R9 period stretched by power-down", n, 92);

    // R10 debug select
    for (int s = 0; s < 4; s++) begin
      dbg_sel_i = 2'(s);
      mism = 0;
      repeat (100) begin
        logic exp_v;
        @(negedge clk_i);
        case (s)
          1: exp_v = msel_o;
          2: exp_v = pre_o;
          3: exp_v = fp_o;
          default: exp_v = 1'b0;
        endcase
        if (dbg_o != exp_v) mism++;
      end
      check("R10 debug mux mismatches", mism, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule